// File: doc/BRIEF.md
# Frame CRC-16 Generator and Checker

This block computes a 16-bit cyclic redundancy check over byte-aligned frames. It uses one serial shift-register divider, one bit per clock, for both directions of a link. In generate mode it divides the frame, followed by sixteen zero bits that it supplies itself, by the polynomial x^16+x^12+x^5+1. The remainder it leaves is the check word that the sender appends to the data. In check mode it runs the same division over a received frame whose last two bytes are that check word. It adds no zero bits, and it reports an error when the remainder is not zero.

Bytes arrive through a valid/ready handshake, with markers for the first and last byte of a frame and a mode select that is captured with the first byte. When a frame ends, the block raises a one-cycle done pulse. During that pulse the 16-bit remainder, the CRC error flag and a frame-length violation flag are valid. Splitting a file into frames and inserting the check word into the outgoing stream are left to the surrounding logic.

Top module: `frame_crc16`

## Requirements
- R1: The divider register is cleared when a byte marked first is accepted. Each bit enters the register most significant bit first, with `next = {r[14:0], bit} ^ (r[15] ? 16'h1021 : 0)`, and no final inversion is applied. In generate mode (`chk_mode`=0), `result` equals the frame's bytes multiplied by x^16, modulo x^16+x^12+x^5+1. For the ASCII bytes "123456789" this gives 16'h31C3.
- R2: After a byte is accepted, `in_ready` stays low for the 8 cycles in which that byte's bits are shifted.
- R3: In generate mode, after the last byte has been shifted, 16 further zero bits are shifted. `done` is high in the 24th cycle after the handshake of the last byte. In check mode no padding is added and `done` is high in the 8th cycle after that handshake.
- R4: In check mode (`chk_mode`=1), the frame is the data bytes followed by the check word, high byte first. `result` is the remainder of that frame, and `crc_err` is 1 exactly when that remainder is non-zero. In generate mode `crc_err` is always 0.
- R5: `done` lasts one cycle. `crc_err` and `len_err` are high only while `done` is high. After reset, `in_ready`=1 and `done`, `crc_err` and `len_err` are 0.
- R6: `len_err` is raised with `done` when a generate-mode frame has more than 127 bytes, or when a check-mode frame has more than 129 bytes (127 data bytes plus 2 check bytes).
- R7: A byte marked first that arrives while a frame is open discards the partial frame and starts a new one. No `done` pulse is produced for the discarded frame.
- R8: A byte accepted while no frame is open and not marked first is dropped. It produces no `done` pulse, leaves `in_ready` high and does not disturb the next frame.
- R9: The mode is captured with the first byte of a frame. Changes to `chk_mode` during the rest of that frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Engine can take a byte |
| in_data | input | 8 | Frame byte |
| in_first | input | 1 | Byte opens a frame |
| in_last | input | 1 | Byte closes the frame |
| chk_mode | input | 1 | 0 = generate, 1 = check; sampled with the first byte |
| done | output | 1 | One-cycle pulse when the frame result is valid |
| result | output | 16 | Remainder of the division |
| crc_err | output | 1 | Check-mode remainder non-zero (valid with done) |
| len_err | output | 1 | Frame exceeds the byte limit for its mode (valid with done) |

## Verification
The hardest case to reach is the length limit. A limit violation only becomes visible when a frame is one byte past the 127- or 129-byte boundary. The stimulus therefore streams full-size frames of exactly the limit and of one more byte in each mode. Check-mode correctness needs a valid check word, so every generate-mode result from the single-byte sweep is fed back as a received frame. The frame is sent once intact and once with one flipped data bit, which shows that a good frame gives a zero remainder and that a damaged one is flagged. A frame abandoned by a new start marker, and a stray byte outside any frame, are both followed by a known vector to show that no state leaks through.

// File: rtl/crc_frame_pkg.sv
package crc_frame_pkg;

    localparam int CRC_W  = 16;
    localparam int BYTE_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    typedef enum logic [1:0] {
        ST_ACCEPT,
        ST_SHIFT,
        ST_PAD,
        ST_DONE
    } crc_state_e;

    typedef struct packed {
        logic start;      // first byte of a frame accepted
        logic take;       // byte accepted into the datapath
        logic shift_en;   // one division step this cycle
        logic shift_zero; // step uses a padding zero
    } crc_cmd_t;

    // One step of the augmented (bit-in at LSB) long division
    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0] r,
        input logic             b,
        input logic [CRC_W-1:0] poly
    );
        logic [CRC_W-1:0] shifted;
        shifted = {r[CRC_W-2:0], b};
        return r[CRC_W-1] ? (shifted ^ poly) : shifted;
    endfunction

endpackage

// File: rtl/crc_shift_unit.sv
module crc_shift_unit
    import crc_frame_pkg::*;
#(
    parameter int               REM_W  = CRC_W,
    parameter int               DATA_W = BYTE_W,
    parameter logic [REM_W-1:0] POLY   = CRC_POLY
) (
    input  logic              clk,
    input  logic              rst,
    input  crc_cmd_t          cmd,
    input  logic [DATA_W-1:0] byte_in,
    output logic [REM_W-1:0]  rem
);
    logic [DATA_W-1:0] sh_q;
    logic              bit_in;

    assign bit_in = cmd.shift_zero ? 1'b0 : sh_q[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            rem  <= '0;
        end else begin
            if (cmd.take)
                sh_q <= byte_in;
            else if (cmd.shift_en)
                sh_q <= {sh_q[DATA_W-2:0], 1'b0};

            if (cmd.start)
                rem <= '0;
            else if (cmd.shift_en)
                rem <= crc_step(rem, bit_in, POLY);
        end
    end
endmodule

// File: rtl/crc_len_guard.sv
module crc_len_guard #(
    parameter int MAX_BYTES = 127,
    parameter int TAIL      = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic start,
    input  logic chk,
    output logic over
);
    localparam int CNT_W = $clog2(MAX_BYTES + TAIL + 1) + 1;
    localparam logic [CNT_W-1:0] GEN_LIM = CNT_W'(MAX_BYTES);
    localparam logic [CNT_W-1:0] CHK_LIM = CNT_W'(MAX_BYTES + TAIL);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (take) begin
            if (start)
                cnt_q <= CNT_W'(1);
            else if (cnt_q != '1)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign over = (cnt_q == '0) || (cnt_q > (chk ? CHK_LIM : GEN_LIM));
endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
    import crc_frame_pkg::*;
#(
    parameter int DATA_W   = BYTE_W,
    parameter int PAD_BITS = CRC_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  logic     in_first,
    input  logic     in_last,
    input  logic     chk_mode,
    output logic     in_ready,
    output crc_cmd_t cmd,
    output logic     done,
    output logic     frame_chk,
    output logic     in_frame
);
    localparam int MAXC = (DATA_W > PAD_BITS) ? DATA_W : PAD_BITS;
    localparam int CW   = $clog2(MAXC + 1);

    crc_state_e    state_q;
    logic [CW-1:0] bit_q;
    logic          last_q;
    logic          hs;

    assign in_ready       = (state_q == ST_ACCEPT);
    assign hs             = in_valid && in_ready;
    assign cmd.take       = hs && (in_first || in_frame);
    assign cmd.start      = hs && in_first;
    assign cmd.shift_en   = (state_q == ST_SHIFT) || (state_q == ST_PAD);
    assign cmd.shift_zero = (state_q == ST_PAD);
    assign done           = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_ACCEPT;
            bit_q     <= '0;
            last_q    <= 1'b0;
            frame_chk <= 1'b0;
            in_frame  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ACCEPT: begin
                    if (cmd.take) begin
                        state_q <= ST_SHIFT;
                        bit_q   <= '0;
                        last_q  <= in_last;
                        if (in_first) begin
                            in_frame  <= 1'b1;
                            frame_chk <= chk_mode;
                        end
                    end
                end
                ST_SHIFT: begin
                    bit_q <= bit_q + 1'b1;
                    if (bit_q == CW'(DATA_W - 1)) begin
                        bit_q <= '0;
                        if (!last_q)
                            state_q <= ST_ACCEPT;
                        else if (frame_chk)
                            state_q <= ST_DONE;
                        else
                            state_q <= ST_PAD;
                    end
                end
                ST_PAD: begin
                    bit_q <= bit_q + 1'b1;
                    if (bit_q == CW'(PAD_BITS - 1))
                        state_q <= ST_DONE;
                end
                ST_DONE: begin
                    state_q  <= ST_ACCEPT;
                    in_frame <= 1'b0;
                end
                default: state_q <= ST_ACCEPT;
            endcase
        end
    end
endmodule

// File: rtl/frame_crc16.sv
module frame_crc16
    import crc_frame_pkg::*;
#(
    parameter int               REM_W     = CRC_W,
    parameter int               DATA_W    = BYTE_W,
    parameter logic [REM_W-1:0] POLY      = CRC_POLY,
    parameter int               MAX_BYTES = 127
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    input  logic              chk_mode,
    output logic              done,
    output logic [REM_W-1:0]  result,
    output logic              crc_err,
    output logic              len_err
);
    localparam int TAIL_BYTES = REM_W / DATA_W;

    crc_cmd_t   cmd;
    logic       frame_chk;
    logic       in_frame;
    logic       over;

    crc_seq_ctrl #(.DATA_W(DATA_W), .PAD_BITS(REM_W)) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .chk_mode(chk_mode), .in_ready(in_ready),
        .cmd(cmd), .done(done), .frame_chk(frame_chk), .in_frame(in_frame)
    );

    crc_shift_unit #(.REM_W(REM_W), .DATA_W(DATA_W), .POLY(POLY)) u_shift (
        .clk(clk), .rst(rst), .cmd(cmd), .byte_in(in_data), .rem(result)
    );

    crc_len_guard #(.MAX_BYTES(MAX_BYTES), .TAIL(TAIL_BYTES)) u_len (
        .clk(clk), .rst(rst), .take(cmd.take), .start(cmd.start),
        .chk(frame_chk), .over(over)
    );

    assign crc_err = done && frame_chk && (result != '0);
    assign len_err = done && over;
endmodule

// File: rtl/frame_crc16_checker.sv
module frame_crc16_checker (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic take,
    input logic done,
    input logic crc_err,
    input logic len_err,
    input logic frame_chk
);
    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (rst)
        take |=> !in_ready);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_crc_err_qual_R5: assert property (@(posedge clk) disable iff (rst)
        crc_err |-> done);

    assert_len_err_qual_R6: assert property (@(posedge clk) disable iff (rst)
        len_err |-> done);

    assert_gen_no_err_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !frame_chk) |-> !crc_err);

    assert_done_not_ready_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);
endmodule

bind frame_crc16 frame_crc16_checker u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .take(cmd.take),
    .done(done), .crc_err(crc_err), .len_err(len_err), .frame_chk(frame_chk)
);

// File: tb/frame_crc16_bench.sv
`timescale 1ns/1ps
module frame_crc16_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_first = 1'b0;
    logic        in_last = 1'b0;
    logic        chk_mode = 1'b0;
    logic        done;
    logic [15:0] result;
    logic        crc_err;
    logic        len_err;

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    logic [7:0] buf_q [0:135];

    always #2 clk = ~clk;

    frame_crc16 u_frame_crc16 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_first(in_first), .in_last(in_last),
        .chk_mode(chk_mode), .done(done), .result(result),
        .crc_err(crc_err), .len_err(len_err)
    );

    always @(negedge clk) if (done === 1'b1) done_cnt++;

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) begin
            c = c ^ {buf_q[i], 8'h00};
            for (int j = 0; j < 8; j++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] d, input bit f, input bit l, input bit m);
        in_data = d; in_first = f; in_last = l; chk_mode = m; in_valid = 1'b1;
        while (in_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (done !== 1'b1 && lat < 60) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic send_frame(input int n, input bit m, output int lat);
        for (int i = 0; i < n; i++)
            send_byte(buf_q[i], i == 0, i == n - 1, m);
        wait_done(lat);
    endtask

    task automatic load_ascii;
        for (int i = 0; i < 9; i++) buf_q[i] = 8'h31 + 8'(i);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        int dc;
        logic [15:0] g;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5 reset state
        check(in_ready === 1'b1, "R5 reset ready", in_ready, 1);
        check(done === 1'b0 && crc_err === 1'b0 && len_err === 1'b0, "R5 reset outputs",
              {done, crc_err, len_err}, 0);

        // R1 known vector
        load_ascii();
        send_frame(9, 1'b0, lat);
        check(result === 16'h31C3, "R1 ascii vector", result, 16'h31C3);
        check(lat == 24, "R3 gen latency", lat, 24);
        @(negedge clk);
        check(done === 1'b0, "R5 done one cycle", done, 0);

        // R1/R4 sweep of every single-byte frame
        for (int b = 0; b < 256; b++) begin
            buf_q[0] = 8'(b);
            g = ref_crc(1);
            send_byte(8'(b), 1'b1, 1'b1, 1'b0);
            check(in_ready === 1'b0, "R2 ready low while shifting", in_ready, 0);
            wait_done(lat);
            check(result === g && crc_err === 1'b0, "R1 single byte gen", result, g);
            @(negedge clk);
            buf_q[1] = g[15:8]; buf_q[2] = g[7:0];
            send_frame(3, 1'b1, lat);
            check(result === 16'h0 && crc_err === 1'b0, "R4 good frame", {crc_err, result}, 0);
            check(lat == 8, "R3 chk latency", lat, 8);
            @(negedge clk);
            buf_q[0] = 8'(b) ^ 8'h10;
            send_frame(3, 1'b1, lat);
            check(result !== 16'h0 && crc_err === 1'b1, "R4 corrupt frame", crc_err, 1);
            @(negedge clk);
        end

        // R6 length limits
        for (int i = 0; i < 136; i++) buf_q[i] = 8'(i * 7 + 3);
        g = ref_crc(127);
        send_frame(127, 1'b0, lat);
        check(len_err === 1'b0 && result === g, "R6 gen 127 ok", {len_err, result}, g);
        @(negedge clk);
        buf_q[127] = g[15:8]; buf_q[128] = g[7:0];
        send_frame(129, 1'b1, lat);
        check(len_err === 1'b0 && crc_err === 1'b0, "R6 chk 129 ok", {len_err, crc_err}, 0);
        @(negedge clk);
        send_frame(128, 1'b0, lat);
        check(len_err === 1'b1, "R6 gen 128 over", len_err, 1);
        @(negedge clk);
        send_frame(130, 1'b1, lat);
        check(len_err === 1'b1, "R6 chk 130 over", len_err, 1);
        @(negedge clk);

        // R7 restart mid-frame
        dc = done_cnt;
        send_byte(8'hAA, 1'b1, 1'b0, 1'b0);
        send_byte(8'h55, 1'b0, 1'b0, 1'b0);
        send_byte(8'h0F, 1'b0, 1'b0, 1'b0);
        load_ascii();
        send_frame(9, 1'b0, lat);
        check(result === 16'h31C3, "R7 restart result", result, 16'h31C3);
        @(negedge clk);
        check(done_cnt == dc + 1, "R7 single done", done_cnt - dc, 1);

        // R8 stray byte outside a frame
        dc = done_cnt;
        send_byte(8'h77, 1'b0, 1'b1, 1'b0);
        check(in_ready === 1'b1, "R8 ready stays high", in_ready, 1);
        repeat (30) @(negedge clk);
        check(done_cnt == dc, "R8 no done", done_cnt - dc, 0);
        send_frame(9, 1'b0, lat);
        check(result === 16'h31C3, "R8 next frame intact", result, 16'h31C3);
        @(negedge clk);

        // R9 mode change after first byte ignored
        send_byte(buf_q[0], 1'b1, 1'b0, 1'b0);
        for (int i = 1; i < 9; i++) send_byte(buf_q[i], 1'b0, i == 8, 1'b1);
        wait_done(lat);
        check(result === 16'h31C3 && lat == 24, "R9 mode held", result, 16'h31C3);
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule